// File: doc/BRIEF.md
# Pulsed Overload Protection Controller

This block supervises the enable of an output power stage. It watches two comparator inputs, one for overload and one for over-temperature, plus a cooldown indication from the thermal sensor. It decides whether the stage may conduct and reports an overload flag and an over-temperature flag. The analog current clamp and the temperature sensing sit outside the block.

With the mode input low, an overload starts a hiccup cycle. The stage stays on for a grace window, then it is switched off for ten times that window, and then it is retried for one window. The block returns to normal operation only after a retry window with no overload at all. With the mode input high, the block never switches the stage off. It only reports the overload while the clamp is active. A thermal trip overrides everything: the stage goes off and the hiccup timers hold their value until the cooldown indication arrives.

All timing is counted in ticks of a prescaled clock. The default is a 1 kHz tick from a 250 MHz clock, with a 90-tick window and a 900-tick off time. The asynchronous inputs pass through two flops first, so each input reaches the control logic two clock edges late.

Top module: `ovl_guard`

## Requirements
- R1: After reset, `stage_en` is 1 and both `ovl_flag` and `hot_flag` are 0.
- R2: With `static_mode`=0, an overload keeps `stage_en` at 1 for exactly ON_TICKS ticks (the grace window). `stage_en` then goes to 0, even if the overload has gone away in the meantime.
- R3: `ovl_flag` rises in the same cycle as the shutdown. It stays 1 through the off period and the retry window.
- R4: The off period lasts ON_TICKS×OFF_RATIO ticks. After it, `stage_en` returns to 1 for a retry window of ON_TICKS ticks.
- R5: If the overload is seen in any cycle of the retry window, another off period of the same length follows.
- R6: A whole retry window with no overload returns the block to normal. `ovl_flag` clears while `stage_en` is 1.
- R7: With `static_mode`=1, `stage_en` is never driven to 0 by an overload. `ovl_flag` follows the synchronised overload input.
- R8: A change from `static_mode`=1 to 0 while an overload is present starts a fresh grace window. During that window `ovl_flag` is 0.
- R9: `hot_raw`=1 forces `stage_en` to 0 and sets `hot_flag`. Both stay that way after `hot_raw` falls, until `cool_raw` is seen while `hot_raw` is low.
- R10: While `hot_flag` is 1, the hiccup state and its timers hold. Time spent hot does not count toward the off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| static_mode | input | 1 | 1 = static clamp reporting, 0 = hiccup protection |
| ovl_raw | input | 1 | Overload comparator, asynchronous |
| hot_raw | input | 1 | Over-temperature trip comparator, asynchronous |
| cool_raw | input | 1 | Cooldown release comparator, asynchronous |
| stage_en | output | 1 | Permission for the power stage to conduct |
| ovl_flag | output | 1 | Overload diagnostic flag |
| hot_flag | output | 1 | Over-temperature diagnostic flag |

## Verification
A hiccup state that is wrong shows on `stage_en` and `ovl_flag` no later than the end of the current window. A timer that is one tick too short or too long moves the shutdown or the re-enable edge by a whole tick. The bench therefore samples on both sides of each expected edge, with a margin smaller than one tick. If a frozen timer kept running during a thermal trip, it would show as an early re-enable right after the cooldown. If the retry check were lost, the flag would clear after a dirty retry window.

// File: rtl/ovl_guard_pkg.sv
// Shared types for the pulsed overload protection controller.
package ovl_guard_pkg;
    // Hiccup sequencer states
    typedef enum logic [1:0] {
        HC_IDLE  = 2'd0,  // normal, no overload being handled
        HC_GRACE = 2'd1,  // overload seen, stage still on for the grace window
        HC_COOL  = 2'd2,  // stage switched off for the long off period
        HC_PROBE = 2'd3   // stage retried, watching for a clean window
    } hc_state_t;
endpackage

// File: rtl/ovl_sync.sv
// Two-flop synchroniser for a bundle of independent asynchronous bits.
// Assumes each bit is a slow level signal; no relation between bits is kept.
module ovl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Two flops per bit; reset to the inactive level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/ovl_tick.sv
// Prescaler that makes a one-cycle tick every CLK_PER_TICK clocks.
// clr holds the phase at zero, so a window starts on an exact boundary.
// en freezes the phase without losing it. Assumes CLK_PER_TICK >= 2.
module ovl_tick #(
    parameter int CLK_PER_TICK = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PW = $clog2(CLK_PER_TICK);
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_TICK - 1);

    logic [PW-1:0] phase;

    // Phase counter: cleared, frozen or advanced
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase <= '0;
        end else if (en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end

    // Tick on the last phase of each period
    always_comb tick = en && !clr && (phase == LAST);
endmodule

// File: rtl/ovl_hiccup.sv
// Hiccup sequencer: grace window, long off period, retry window with clean check.
// Assumes synchronised inputs. run=0 freezes all state (thermal priority).
// static_sel=1 forces the idle state, so leaving static mode starts a fresh grace window.
module ovl_hiccup
    import ovl_guard_pkg::*;
#(
    parameter int ON_TICKS  = 90,
    parameter int OFF_RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic static_sel,
    input  logic run,
    input  logic tick,
    input  logic ovl,
    output logic idle,
    output logic stage_off,
    output logic flag
);
    localparam int OFF_TICKS = ON_TICKS * OFF_RATIO;
    localparam int CW = $clog2(OFF_TICKS + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_TICKS - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_TICKS - 1);

    hc_state_t st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic seen, seen_n;

    // Next-state and tick counter logic
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        seen_n = seen;
        if (static_sel) begin
            st_n   = HC_IDLE;
            cnt_n  = '0;
            seen_n = 1'b0;
        end else if (run) begin
            case (st)
                HC_IDLE: begin
                    if (ovl) begin
                        st_n  = HC_GRACE;
                        cnt_n = '0;
                    end
                end
                HC_GRACE: begin
                    if (tick) begin
                        if (cnt == ON_LAST) begin
                            st_n  = HC_COOL;
                            cnt_n = '0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                HC_COOL: begin
                    if (tick) begin
                        if (cnt == OFF_LAST) begin
                            st_n   = HC_PROBE;
                            cnt_n  = '0;
                            seen_n = 1'b0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                HC_PROBE: begin
                    seen_n = seen | ovl;
                    if (tick) begin
                        if (cnt == ON_LAST) begin
                            st_n   = (seen | ovl) ? HC_COOL : HC_IDLE;
                            cnt_n  = '0;
                            seen_n = 1'b0;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                default: st_n = HC_IDLE;
            endcase
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= HC_IDLE;
            cnt  <= '0;
            seen <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            seen <= seen_n;
        end
    end

    // Decoded outputs
    always_comb begin
        idle      = (st == HC_IDLE);
        stage_off = (st == HC_COOL);
        flag      = (st == HC_COOL) || (st == HC_PROBE);
    end
endmodule

// File: rtl/ovl_thermal.sv
// Thermal latch with hysteresis: set by the trip comparator, cleared only by
// the cooldown comparator while the trip is low. Assumes synchronised inputs.
module ovl_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic hot,
    input  logic cool,
    output logic hot_st
);
    // Set/release latch, trip has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_st <= 1'b0;
        end else if (hot) begin
            hot_st <= 1'b1;
        end else if (cool) begin
            hot_st <= 1'b0;
        end
    end
endmodule

// File: rtl/ovl_guard.sv
// Top of the pulsed overload protection controller.
// Synchronises the comparators and runs the hiccup sequencer on a prescaled tick.
// Thermal shutdown takes priority over the hiccup state and freezes it.
// Assumes static_mode is a quasi-static control from the clk domain.
module ovl_guard #(
    parameter int CLK_PER_TICK = 250000,
    parameter int ON_TICKS     = 90,
    parameter int OFF_RATIO    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic static_mode,
    input  logic ovl_raw,
    input  logic hot_raw,
    input  logic cool_raw,
    output logic stage_en,
    output logic ovl_flag,
    output logic hot_flag
);
    logic ovl_s, hot_s, cool_s;
    logic tick, hc_idle, hc_off, hc_flag, hot_st;

    ovl_sync #(.W(3)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_async({ovl_raw, hot_raw, cool_raw}),
        .q_sync({ovl_s, hot_s, cool_s})
    );

    ovl_thermal u_therm (
        .clk(clk), .rst_n(rst_n), .hot(hot_s), .cool(cool_s), .hot_st(hot_st)
    );

    ovl_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n),
        .clr(hc_idle || static_mode), .en(!hot_st), .tick(tick)
    );

    ovl_hiccup #(.ON_TICKS(ON_TICKS), .OFF_RATIO(OFF_RATIO)) u_hic (
        .clk(clk), .rst_n(rst_n),
        .static_sel(static_mode), .run(!hot_st), .tick(tick), .ovl(ovl_s),
        .idle(hc_idle), .stage_off(hc_off), .flag(hc_flag)
    );

    // Output merge: thermal first, then mode selects hiccup or clamp report
    always_comb begin
        stage_en = !hot_st && (static_mode || !hc_off);
        ovl_flag = static_mode ? ovl_s : hc_flag;
        hot_flag = hot_st;
    end
endmodule

// File: rtl/ovl_guard_chk.sv
// Property checker for ovl_guard, bound into every instance.
module ovl_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic static_mode,
    input logic stage_en,
    input logic ovl_flag,
    input logic hot_flag,
    input logic cool_s
);
    AST_HOT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hot_flag |-> !stage_en); // R9

    AST_STATIC_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (static_mode && $past(static_mode) && !hot_flag) |-> stage_en); // R7

    AST_FLAG_AT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_mode && !hot_flag && !$past(hot_flag) && $fell(stage_en)) |-> ovl_flag); // R3

    AST_CLEAR_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!static_mode && !$past(static_mode) && $fell(ovl_flag)) |-> stage_en); // R6

    AST_HOT_RELEASE_COOL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hot_flag) |-> $past(cool_s)); // R9

    AST_HOT_FREEZES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_flag && $past(hot_flag) && !static_mode && !$past(static_mode))
            |-> $stable(ovl_flag)); // R10
endmodule

bind ovl_guard ovl_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode),
    .stage_en(stage_en), .ovl_flag(ovl_flag), .hot_flag(hot_flag), .cool_s(cool_s)
);

// File: tb/ovl_guard_test.sv
// Directed bench: one task per scenario. Tick = 4 clocks, window = 3 ticks (12 clocks),
// off period = 30 ticks (120 clocks). An input change reaches the sequencer after 2 edges.
module ovl_guard_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic static_mode = 1'b0;
    logic ovl_raw = 1'b0;
    logic hot_raw = 1'b0;
    logic cool_raw = 1'b0;
    logic stage_en, ovl_flag, hot_flag;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ovl_guard #(.CLK_PER_TICK(4), .ON_TICKS(3), .OFF_RATIO(10)) uut (
        .clk(clk), .rst_n(rst_n), .static_mode(static_mode),
        .ovl_raw(ovl_raw), .hot_raw(hot_raw), .cool_raw(cool_raw),
        .stage_en(stage_en), .ovl_flag(ovl_flag), .hot_flag(hot_flag)
    );

    // Advance n edges, then sit at the falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 stage_en", stage_en, 1'b1);
        chk("R1 ovl_flag", ovl_flag, 1'b0);
        chk("R1 hot_flag", hot_flag, 1'b0);
    endtask

    // Full hiccup: grace 12, off 120, dirty retry, off again, clean retry
    task automatic t_hiccup();
        ovl_raw = 1'b1;                       // edge count k from here
        step(11);                             // k=12, grace ends at k=14
        chk("R2 on in grace", stage_en, 1'b1);
        chk("R2 flag low in grace", ovl_flag, 1'b0);
        step(4);                              // k=16
        chk("R2 off after grace", stage_en, 1'b0);
        chk("R3 flag at shutdown", ovl_flag, 1'b1);
        step(114);                            // k=130, off ends k=134
        chk("R4 still off", stage_en, 1'b0);
        step(8);                              // k=138, in retry
        chk("R4 retry on", stage_en, 1'b1);
        chk("R3 flag in retry", ovl_flag, 1'b1);
        ovl_raw = 1'b0;                       // overload still seen early in window
        step(12);                             // k=150, retry ended k=146
        chk("R5 dirty retry off again", stage_en, 1'b0);
        step(120);                            // k=270, off ends k=266
        chk("R6 second retry on", stage_en, 1'b1);
        chk("R6 flag held in retry", ovl_flag, 1'b1);
        step(12);                             // k=282, clean retry ends k=278
        chk("R6 flag cleared", ovl_flag, 1'b0);
        chk("R6 stage on", stage_en, 1'b1);
    endtask

    // Static clamp report, then drop to dynamic with overload present
    task automatic t_static();
        static_mode = 1'b1;
        ovl_raw = 1'b1;
        step(4);
        chk("R7 flag follows", ovl_flag, 1'b1);
        chk("R7 stays on", stage_en, 1'b1);
        step(200);
        chk("R7 never off", stage_en, 1'b1);
        static_mode = 1'b0;                   // fresh grace, ends 12 edges later
        step(9);
        chk("R8 fresh grace on", stage_en, 1'b1);
        chk("R8 flag low in grace", ovl_flag, 1'b0);
        step(5);
        chk("R8 off after grace", stage_en, 1'b0);
        ovl_raw = 1'b0;
        step(160);
        chk("R8 recovered", ovl_flag, 1'b0);
        static_mode = 1'b1;
        step(4);
        chk("R7 flag clear", ovl_flag, 1'b0);
        static_mode = 1'b0;
        step(4);
    endtask

    // Thermal trip during the off period; timers must hold
    task automatic t_thermal();
        ovl_raw = 1'b1;
        step(19);                             // k=20, in off period since k=14
        ovl_raw = 1'b0;
        hot_raw = 1'b1;
        step(5);
        chk("R9 hot flag set", hot_flag, 1'b1);
        chk("R9 stage off", stage_en, 1'b0);
        step(150);
        hot_raw = 1'b0;
        step(20);
        chk("R9 hot held without cool", hot_flag, 1'b1);
        chk("R10 flag frozen", ovl_flag, 1'b1);
        cool_raw = 1'b1;
        step(4);
        cool_raw = 1'b0;
        chk("R9 hot released", hot_flag, 1'b0);
        chk("R10 off period resumes", stage_en, 1'b0);
        step(60);
        chk("R10 still in off period", stage_en, 1'b0);
        step(80);
        chk("R10 retry after remaining time", stage_en, 1'b1);
        step(20);
        chk("R10 recovered", ovl_flag, 1'b0);
        // Trip from normal operation
        hot_raw = 1'b1;
        step(4);
        chk("R9 trip from normal", stage_en, 1'b0);
        hot_raw = 1'b0;
        cool_raw = 1'b1;
        step(4);
        cool_raw = 1'b0;
        chk("R9 on after cool", stage_en, 1'b1);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_hiccup();
        t_static();
        t_thermal();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule